// File: doc/BRIEF.md
# Multi-Mode Integer Divider

This block is a sequential integer divider for a processor's execute stage. A 4-bit operation code selects one of twelve operations: quotient or remainder, signed or unsigned, at full word width (64 bits by default) or at half width (32 bits). Two further quotient operations use an extended dividend, where the dividend is shifted left by the selected width before the divide. The result is always a full-width word.

An operation is accepted with a valid/ready handshake. The block then runs a restoring shift-subtract loop on the operand magnitudes and produces one quotient bit per cycle. A sign fix-up step and a range check follow. The result waits behind an output valid/ready handshake, and three status flags come with it: divide by zero, overflow and illegal opcode. Only one operation is in flight at a time.

Top module: `int_divider`

## Requirements
- R1: Opcodes are 0 signed-extended-div-full, 1 unsigned-extended-div-full, 2 signed-div-full, 3 unsigned-div-full, 4 signed-rem-full, 5 unsigned-rem-full, and 6 to 11 the same six operations at half width. Unsigned operations treat both operands as non-negative.
- R2: A signed quotient is rounded toward zero.
- R3: A signed remainder takes the sign of the dividend, whatever the sign of the divisor.
- R4: In the extended operations the numerator is the dividend shifted left by the selected width. Only a selected-width quotient is kept. If the true quotient does not fit that width, the result is zero and out_overflow is set.
- R5: Half-width operations read only the low half of each operand. The half-width result sits in the low half of out_data, and every bit of the upper half equals result bit H-1.
- R6: With a zero divisor at the selected width, a quotient operation returns all ones and a remainder operation returns the dividend. out_div_zero is set, out_overflow is clear, and the result is ready one cycle after acceptance.
- R7: A signed non-extended divide of the most negative value by -1 returns the most negative value and sets out_overflow. A remainder operation never sets out_overflow, and for that input it returns zero.
- R8: Opcodes 12 to 15 complete one cycle after acceptance with a zero result and out_illegal set.
- R9: in_ready is high only when no operation is in flight, so it goes low on the cycle after an acceptance.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data and all three flags hold their values.
- R11: A loop operation raises out_valid exactly iterations+2 clock edges after acceptance. The iteration count is 2W for full-width extended divides, W for other full-width operations and for half-width extended divides, and H for other half-width operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Divider idle, request accepted when both high |
| in_op | input | 4 | Operation code (R1) |
| in_a | input | W | Dividend |
| in_b | input | W | Divisor |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Quotient or remainder |
| out_div_zero | output | 1 | Divisor was zero |
| out_overflow | output | 1 | Quotient did not fit the selected width |
| out_illegal | output | 1 | Opcode 12 to 15 |

## Verification
On every cycle the assertions check the handshake rules: in_ready drops after an acceptance and stays low while a result is pending, and the result and flags hold steady under back-pressure. They also check the one-cycle completion of illegal opcodes and zero divisors, the sign-extended upper half of half-width results, and that remainders never flag overflow. The arithmetic itself can only be shown by the bench's sweeps against a computed model. These sweeps cover truncation toward zero, the sign of the remainder, extended-dividend overflow, and the most-negative-by-minus-one case, along with the exact latency of each iteration class.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_div_zero,
  output logic         out_overflow,
  output logic         out_illegal
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX, S_DONE} st_t;
  st_t st;

  function automatic logic [W-1:0] half_ext(input logic [W-1:0] x, input logic s);
    return {{H{s & x[H-1]}}, x[H-1:0]};
  endfunction

  // request decode
  logic         legal, i32, ihigh, isgn, irem, a_neg, b_neg, b_zero, accept;
  logic [3:0]   sub;
  logic [W-1:0] a_ext, b_ext, mag_a, mag_b;
  logic [CW-1:0] iters;
  logic [DW-1:0] numer, num_load;

  assign accept = in_valid && in_ready;
  assign legal  = in_op < 4'd12;
  assign i32    = in_op >= 4'd6;
  assign sub    = i32 ? in_op - 4'd6 : in_op;
  assign ihigh  = sub < 4'd2;
  assign isgn   = (sub == 4'd0) || (sub == 4'd2) || (sub == 4'd4);
  assign irem   = sub >= 4'd4;
  assign a_ext  = i32 ? half_ext(in_a, isgn) : in_a;
  assign b_ext  = i32 ? half_ext(in_b, isgn) : in_b;
  assign a_neg  = isgn & a_ext[W-1];
  assign b_neg  = isgn & b_ext[W-1];
  assign mag_a  = a_neg ? -a_ext : a_ext;
  assign mag_b  = b_neg ? -b_ext : b_ext;
  assign b_zero = (b_ext == '0);
  assign iters  = (ihigh && !i32) ? CW'(DW) : ((ihigh || !i32) ? CW'(W) : CW'(H));
  assign numer  = ihigh ? ({{W{1'b0}}, mag_a} << (i32 ? H : W)) : {{W{1'b0}}, mag_a};
  assign num_load = numer << (CW'(DW) - iters);

  // loop state
  logic [CW-1:0] cnt;
  logic [DW-1:0] num_q, q_q;
  logic [W-1:0]  rem_q, d_q, res_q;
  logic          high_q, is32_q, remop_q, sgn_q, nq_q, nr_q, dz_q, ovf_q, ill_q;

  // one restoring step
  logic [W:0]   trial, diff;
  logic         ge;
  assign trial = {rem_q, num_q[DW-1]};
  assign diff  = trial - {1'b0, d_q};
  assign ge    = trial >= {1'b0, d_q};

  // sign fix-up and range check
  logic [DW-1:0] lim, qs;
  logic [W-1:0]  rs, pick;
  logic          fit;
  assign lim  = is32_q ? (DW'(1) << (H - 1)) : (DW'(1) << (W - 1));
  assign fit  = sgn_q ? (nq_q ? (q_q <= lim) : (q_q < lim)) : (q_q < (lim << 1));
  assign qs   = nq_q ? -q_q : q_q;
  assign rs   = nr_q ? -rem_q : rem_q;
  assign pick = remop_q ? rs : ((!fit && high_q) ? '0 : qs[W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      num_q <= '0;
      q_q <= '0;
      rem_q <= '0;
      d_q <= '0;
      res_q <= '0;
      high_q <= 1'b0;
      is32_q <= 1'b0;
      remop_q <= 1'b0;
      sgn_q <= 1'b0;
      nq_q <= 1'b0;
      nr_q <= 1'b0;
      dz_q <= 1'b0;
      ovf_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          dz_q  <= legal && b_zero;
          ovf_q <= 1'b0;
          ill_q <= !legal;
          if (!legal) begin
            res_q <= '0;
            st    <= S_DONE;
          end else if (b_zero) begin
            res_q <= irem ? (i32 ? half_ext(in_a, 1'b1) : in_a) : '1;
            st    <= S_DONE;
          end else begin
            high_q  <= ihigh;
            is32_q  <= i32;
            remop_q <= irem;
            sgn_q   <= isgn;
            nq_q    <= a_neg ^ b_neg;
            nr_q    <= a_neg;
            d_q     <= mag_b;
            num_q   <= num_load;
            rem_q   <= '0;
            q_q     <= '0;
            cnt     <= iters;
            st      <= S_RUN;
          end
        end
        S_RUN: begin
          rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
          q_q   <= {q_q[DW-2:0], ge};
          num_q <= num_q << 1;
          cnt   <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIX;
        end
        S_FIX: begin
          res_q <= is32_q ? half_ext(pick, 1'b1) : pick;
          ovf_q <= !remop_q && !fit;
          st    <= S_DONE;
        end
        S_DONE: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready     = (st == S_IDLE);
  assign out_valid    = (st == S_DONE);
  assign out_data     = res_q;
  assign out_div_zero = dz_q;
  assign out_overflow = ovf_q;
  assign out_illegal  = ill_q;
endmodule

module int_divider_props #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_op,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_div_zero,
  input logic         out_overflow,
  input logic         out_illegal
);
  localparam int H = W / 2;
  logic [3:0] op_q;
  logic       bz;
  assign bz = (in_op >= 4'd6) ? (in_b[H-1:0] == '0) : (in_b == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) op_q <= 4'd0;
    else if (in_valid && in_ready) op_q <= in_op;
  end

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_no_ready_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_div_zero)
                                   && $stable(out_overflow) && $stable(out_illegal)));
  p_illegal_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op >= 4'd12) |=> (out_valid && out_illegal && out_data == '0));
  p_zero_div_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op < 4'd12 && bz) |=> (out_valid && out_div_zero && !out_overflow));
  p_half_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q >= 4'd6 && op_q < 4'd12) |-> (out_data[W-1:H] == {H{out_data[H-1]}}));
  p_rem_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_q == 4'd4 || op_q == 4'd5 || op_q == 4'd10 || op_q == 4'd11)) |-> !out_overflow);
endmodule

bind int_divider int_divider_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_div_zero(out_div_zero), .out_overflow(out_overflow), .out_illegal(out_illegal)
);

// File: tb/sim_int_divider.sv
module sim_int_divider;
  localparam int W = 8;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] in_op = 4'd0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid, out_div_zero, out_overflow, out_illegal;
  logic [W-1:0] out_data;

  int checks = 0, fails = 0, ops_done = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  int_divider #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_div_zero(out_div_zero), .out_overflow(out_overflow),
    .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // model: {illegal, div_zero, overflow, result}
  function automatic logic [W+2:0] model(input int op, input int a, input int b);
    int n, sub;
    bit hi, sg, rm, fit;
    longint mask, al, bl, num, q, r, v;
    logic [W-1:0] res;
    if (op >= 12) return {3'b100, {W{1'b0}}};
    n = (op >= 6) ? H : W;
    sub = (op >= 6) ? op - 6 : op;
    hi = sub < 2; sg = (sub == 0 || sub == 2 || sub == 4); rm = sub >= 4;
    mask = (longint'(1) << n) - 1;
    al = a & mask; bl = b & mask;
    if (sg && al[n-1]) al = al - (longint'(1) << n);
    if (sg && bl[n-1]) bl = bl - (longint'(1) << n);
    if (bl == 0) begin
      v = rm ? al : -1;
      v = v & mask;
      res = W'(v);
      if (n == H) res = {{H{res[H-1]}}, res[H-1:0]};
      return {3'b010, res};
    end
    num = hi ? al * (longint'(1) << n) : al;
    q = num / bl; r = num % bl;
    fit = 1'b1;
    if (rm) v = r;
    else begin
      if (sg) fit = (q >= -(longint'(1) << (n-1))) && (q <= (longint'(1) << (n-1)) - 1);
      else    fit = (q <= mask);
      v = (!fit && hi) ? 0 : q;
    end
    v = v & mask;
    res = W'(v);
    if (n == H) res = {{H{res[H-1]}}, res[H-1:0]};
    return {2'b00, !fit, res};
  endfunction

  function automatic string tag_of(input int op, input logic [W+2:0] e);
    int sub;
    if (op >= 12) return "R8";
    if (e[W+1]) return "R6";
    if (e[W]) return "R7";
    sub = (op >= 6) ? op - 6 : op;
    if (op >= 6) return "R5";
    if (sub < 2) return "R4";
    if (sub == 4) return "R3";
    if (sub == 2) return "R2";
    return "R1";
  endfunction

  task automatic do_op(input int op, input int a, input int b);
    logic [W+2:0] e;
    int lat, exp_lat, sub, hold;
    string t;
    logic [W-1:0] first;
    e = model(op, a, b);
    t = tag_of(op, e);
    sub = (op >= 6) ? op - 6 : op;
    if (op >= 12 || e[W+1]) exp_lat = 0;
    else if (sub < 2 && op < 6) exp_lat = 2*W + 1;
    else if (sub < 2 || op < 6) exp_lat = W + 1;
    else exp_lat = H + 1;
    in_valid = 1'b1; in_op = 4'(op); in_a = W'(a); in_b = W'(b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_lat > 0) check(in_ready == 1'b0, "R9", "busy ready", in_ready, 0);
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    check(lat == exp_lat, "R11", "latency", lat, exp_lat);
    check(out_data == e[W-1:0], t, $sformatf("op %0d a %0h b %0h data", op, a, b), out_data, e[W-1:0]);
    check({out_illegal, out_div_zero, out_overflow} == e[W+2:W], t, "flags",
          {out_illegal, out_div_zero, out_overflow}, e[W+2:W]);
    first = out_data;
    hold = ops_done % 3;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
    end
    if (hold > 0) check(out_valid && out_data == first, "R10", "held result", out_data, first);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    ops_done++;
  endtask

  initial begin
    int bl [16] = '{0, 1, 2, 3, 5, 7, 16, 64, 100, 127, 128, 129, 200, 253, 254, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R9", "reset state", {in_ready, out_valid}, 2'b10);
    // half-width ops: exhaustive low halves, junk in upper halves (R5)
    for (int op = 6; op < 12; op++)
      for (int la = 0; la < 16; la++)
        for (int lb = 0; lb < 16; lb++)
          do_op(op, (((la * 7 + lb + 3) & 15) << 4) | la, (((lb * 5 + 9) & 15) << 4) | lb);
    // full-width ops: sampled dividends against a fixed divisor set (R1 R2 R3 R4 R7)
    for (int op = 0; op < 6; op++)
      for (int ai = 0; ai < 32; ai++)
        for (int bi = 0; bi < 16; bi++)
          do_op(op, (ai == 31) ? 128 : (ai * 8 + ai % 7), bl[bi]);
    // illegal opcodes (R8)
    for (int op = 12; op < 16; op++) do_op(op, 8'h5a, 8'h03);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule